// File: doc/BRIEF.md
# Multiprocessor Serial Transceiver

This block is an asynchronous serial transmitter and receiver. A frame has a low start bit, seven or eight data bits sent least significant bit first, an optional extra bit, and one high stop bit. A two-bit `mode` input sets what the extra bit carries. In mode 1, the multiprocessor mode, it is an address/data marker. In mode 0 it is an even parity bit, when the `PARITY_EN` parameter is set. Modes 2 and 3 send no extra bit and always use eight data bits. Mode 3 also watches the receive line for a long low level, called a sync break.

Software uses a five-bit register port with two addresses. Address 0 is control: receive enable, transmit enable, data length, address/data marker, and a clear-errors strobe. Address 1 is status: framing, overrun, parity and break flags. Bytes pass in and out through valid/ready handshakes. A fixed `CLK_DIV` parameter sets the timing. The receiver samples at `OVS` (16) ticks per bit, and one bit time is `CLK_DIV*OVS` clocks.

Top module: `mpuart`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 0, `rx_valid` is 0, `status` is 0, and control (address 0) and status (address 1) both read 0.
- R2: Control bit 2 selects the data length: 0 gives 7 data bits, 1 gives 8. A transmitted frame is a 0 start bit, then the data bits LSB first, then the optional extra bit, then a 1 stop bit. A received 7-bit byte appears with bit 7 at 0.
- R3: In modes 2 and 3, frames carry 8 data bits and no extra bit, whatever control bit 2 holds.
- R4: In mode 1, control bit 3 is sent after the data bits as the marker bit (1 means address frame, 0 means data frame). No parity bit is sent or checked in this mode.
- R5: In mode 1, reading control bit 3 returns the marker of the last frame received. In other modes it returns the written value.
- R6: In mode 0 with `PARITY_EN`, an even parity bit over the data bits follows the data. A received mismatch sets status bit 2. A frame with correct parity sets no error.
- R7: A received stop bit of 0 sets status bit 0 (framing error).
- R8: If a frame completes while `rx_valid` is set and `rx_ready` is low, status bit 1 (overrun) is set. `rx_data` keeps the unread byte and stays stable until it is taken.
- R9: Writing control with bit 4 set clears status bits 0 to 2. A control write with bit 4 clear leaves them unchanged. Control bit 4 always reads 0.
- R10: Clearing control bit 0 (receive enable) during a frame abandons that frame. It never raises `rx_valid`.
- R11: When control bit 1 (transmit enable) is 0, `txd` is 1 from the next cycle on and `tx_ready` is 0. Clearing the bit mid-frame cuts the frame short.
- R12: In mode 3, a low level on `rxd` for at least 11 bit times sets status bit 3, even when reception is disabled. A 10-bit-time low does not set it, and no other mode sets it. The bit stays set until a write to address 1 with data bit 3 set.
- R13: A byte is accepted on a cycle with `tx_valid` and `tx_ready` both high, and its start bit appears on `txd` in the next cycle. `rx_data` is valid while `rx_valid` is high, and the byte is released by `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode 0..3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data for `reg_addr` |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the byte |
| status | output | 4 | {break, parity, overrun, framing} |

## Verification
Errors in the transmit shift register or the bit counter show on `txd` within one bit time, as a wrong, missing or extra bit at a mid-bit sample. The bench compares every bit position of every frame, so such a fault is reported in the first frame that uses the affected field. A wrong receive sampling phase or bit index shows up when the frame completes: a corrupted `rx_data`, a missing `rx_valid`, or a spurious status flag. The status flags are checked after each received frame. Break counting faults show at the boundary between a 10-bit and a 12-bit low level.

// File: rtl/mpuart_pkg.sv
// Package: shared types and register layout for the serial transceiver.
// Assumes: 5-bit register port, two addresses.
package mpuart_pkg;

    localparam int REG_W = 5;

    // control register fields (address 0)
    localparam int C_RXE = 0;
    localparam int C_TXE = 1;
    localparam int C_LEN = 2;
    localparam int C_ADR = 3;
    localparam int C_CLR = 4;

    // status register fields (address 1)
    localparam int S_FRE = 0;
    localparam int S_ORE = 1;
    localparam int S_PAR = 2;
    localparam int S_BRK = 3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

    // number of data bits for a given length bit
    function automatic logic [3:0] data_bits(input logic len8);
        return len8 ? 4'd8 : 4'd7;
    endfunction

    // whether a frame carries a marker/parity bit in the given mode
    function automatic logic has_extra(input logic [1:0] mode, input logic par_en);
        return (mode == 2'd1) || ((mode == 2'd0) && par_en);
    endfunction

endpackage

// File: rtl/mpuart_baud.sv
// Module: oversampling tick generator.
// Emits a one-cycle tick every DIV clocks. Assumes DIV >= 1.
module mpuart_baud #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every
            // every cycle is a tick once out of reset
            always_ff @(posedge clk) begin
                tick <= rst_n;
            end
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // free-running divider
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt  <= cnt + 1'b1;
                    tick <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mpuart_tx.sv
// Module: frame transmitter.
// Builds a whole frame when a byte is accepted and shifts it out, one bit
// every BIT_CLKS clocks. Dropping tx_en aborts at once and idles the line.
// Assumes BIT_CLKS >= 2.
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int BIT_CLKS  = 32,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       len8,
    input  logic [1:0] mode,
    input  logic       adr_flag,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd
);

    localparam int CW = $clog2(BIT_CLKS);

    logic [11:0]   shreg;
    logic [11:0]   frame;
    logic [3:0]    nbits;
    logic [3:0]    left;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [3:0]    nd;
    logic          extra;
    logic          xval;
    logic [8:0]    dext;

    // compose the frame image: start, data LSB first, optional extra, stop
    always_comb begin
        nd    = data_bits(len8);
        extra = has_extra(mode, PARITY_EN);
        dext  = {1'b0, (len8 ? tx_data : {1'b0, tx_data[6:0]})};
        xval  = (mode == 2'd1) ? adr_flag : ^dext;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (i < int'(nd)) begin
                frame[1+i] = dext[i];
            end else if ((i == int'(nd)) && extra) begin
                frame[1+i] = xval;
            end
        end
        nbits = nd + 4'd2 + {3'b000, extra};
    end

    // shift engine with bit timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            busy  <= 1'b0;
            cnt   <= '0;
            left  <= '0;
        end else if (!tx_en) begin
            shreg <= '1;
            busy  <= 1'b0;
            cnt   <= '0;
            left  <= '0;
        end else if (!busy) begin
            if (tx_valid) begin
                shreg <= frame;
                busy  <= 1'b1;
                cnt   <= '0;
                left  <= nbits;
            end
        end else if (cnt == CW'(BIT_CLKS - 1)) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[11:1]};
            left  <= left - 1'b1;
            if (left == 4'd1) begin
                busy <= 1'b0;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tx_ready = tx_en && !busy;
    assign txd      = shreg[0];

endmodule

// File: rtl/mpuart_rx.sv
// Module: frame receiver.
// Detects a falling edge, confirms the start bit at mid-bit, then samples
// each bit every OVS ticks at its middle. Pulses done with the stop check.
// Dropping rx_en returns to idle without reporting the frame.
// Assumes rxd_s is already synchronised and OVS is even.
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OVS       = 16,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       rxd_s,
    input  logic       len8,
    input  logic [1:0] mode,
    output logic       done,
    output logic       frm_err,
    output logic       par_err,
    output logic       xbit,
    output logic [7:0] data
);

    localparam int TW = $clog2(OVS);

    rx_state_t     state;
    logic [TW-1:0] tcnt;
    logic [3:0]    idx;
    logic [8:0]    sh;
    logic          prev;
    logic [3:0]    nd;
    logic [3:0]    total;
    logic          extra;
    logic          mid_start;
    logic          mid_bit;

    // frame shape and decoded outputs
    always_comb begin
        nd        = data_bits(len8);
        extra     = has_extra(mode, PARITY_EN);
        total     = nd + {3'b000, extra};
        data      = len8 ? sh[7:0] : {1'b0, sh[6:0]};
        xbit      = sh[nd];
        par_err   = extra && (mode == 2'd0) && (xbit != ^data);
        mid_start = os_tick && (tcnt == TW'(OVS / 2 - 1));
        mid_bit   = os_tick && (tcnt == TW'(OVS - 1));
    end

    // receive state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            tcnt    <= '0;
            idx     <= '0;
            sh      <= '0;
            prev    <= 1'b1;
            done    <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            prev <= rxd_s;
            done <= 1'b0;
            if (!rx_en) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (prev && !rxd_s) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (mid_start) begin
                            tcnt <= '0;
                            idx  <= '0;
                            sh   <= '0;
                            state <= rxd_s ? RX_IDLE : RX_BITS;
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (mid_bit) begin
                            tcnt    <= '0;
                            sh[idx] <= rxd_s;
                            idx     <= idx + 1'b1;
                            if (idx == total - 1'b1) begin
                                state <= RX_STOP;
                            end
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (mid_bit) begin
                            tcnt    <= '0;
                            done    <= 1'b1;
                            frm_err <= !rxd_s;
                            state   <= RX_IDLE;
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mpuart_brk.sv
// Module: long-low (break) detector.
// Counts oversampling ticks while the line is low and enabled; pulses hit
// once when LIMIT ticks have been seen. Saturates until the line rises.
module mpuart_brk #(
    parameter int LIMIT = 176
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic os_tick,
    input  logic rxd_s,
    output logic hit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // low-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || rxd_s) begin
            cnt <= '0;
        end else if (os_tick && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = en && !rxd_s && os_tick && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/mpuart.sv
// Module: multiprocessor serial transceiver, top level.
// Holds the control and status registers, the received-byte holding stage,
// and wires the tick generator, transmitter, receiver and break detector.
// Assumes a synchronous active-low reset and an asynchronous rxd.
module mpuart
    import mpuart_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int OVS        = 16,
    parameter bit PARITY_EN  = 1'b1,
    parameter int BREAK_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [3:0]       status
);

    localparam int BIT_CLKS  = CLK_DIV * OVS;
    localparam int BRK_TICKS = BREAK_BITS * OVS;

    logic       ctrl_rxe;
    logic       ctrl_txe;
    logic       ctrl_len;
    logic       ctrl_adr;
    logic       rx_adr_last;
    logic       fre_q, ore_q, par_q, brk_q;
    logic       len8_eff;
    logic       os_tick;
    logic [1:0] rxd_sync;
    logic       rx_done, rx_ferr, rx_perr, rx_xbit;
    logic [7:0] rx_word;
    logic       brk_hit;
    logic       wr_ctrl, wr_stat, err_clr;

    assign len8_eff = mode[1] | ctrl_len;
    assign wr_ctrl  = reg_wr && !reg_addr;
    assign wr_stat  = reg_wr && reg_addr;
    assign err_clr  = wr_ctrl && reg_wdata[C_CLR];

    // two-stage synchroniser on the serial input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_sync <= 2'b11;
        end else begin
            rxd_sync <= {rxd_sync[0], rxd};
        end
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rxe <= 1'b0;
            ctrl_txe <= 1'b0;
            ctrl_len <= 1'b0;
            ctrl_adr <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_rxe <= reg_wdata[C_RXE];
            ctrl_txe <= reg_wdata[C_TXE];
            ctrl_len <= reg_wdata[C_LEN];
            ctrl_adr <= reg_wdata[C_ADR];
        end
    end

    // error flags, received-marker capture and break flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fre_q       <= 1'b0;
            ore_q       <= 1'b0;
            par_q       <= 1'b0;
            brk_q       <= 1'b0;
            rx_adr_last <= 1'b0;
        end else begin
            if (err_clr) begin
                fre_q <= 1'b0;
                ore_q <= 1'b0;
                par_q <= 1'b0;
            end else if (rx_done) begin
                fre_q <= fre_q | rx_ferr;
                par_q <= par_q | rx_perr;
                ore_q <= ore_q | (rx_valid && !rx_ready);
            end
            if (rx_done && (mode == 2'd1)) begin
                rx_adr_last <= rx_xbit;
            end
            if (wr_stat && reg_wdata[S_BRK]) begin
                brk_q <= 1'b0;
            end else if (brk_hit) begin
                brk_q <= 1'b1;
            end
        end
    end

    // received-byte holding stage with valid/ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else if (rx_done && !(rx_valid && !rx_ready)) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[C_RXE] = ctrl_rxe;
            reg_rdata[C_TXE] = ctrl_txe;
            reg_rdata[C_LEN] = ctrl_len;
            reg_rdata[C_ADR] = (mode == 2'd1) ? rx_adr_last : ctrl_adr;
        end else begin
            reg_rdata[S_FRE] = fre_q;
            reg_rdata[S_ORE] = ore_q;
            reg_rdata[S_PAR] = par_q;
            reg_rdata[S_BRK] = brk_q;
        end
    end

    assign status = {brk_q, par_q, ore_q, fre_q};

    mpuart_baud #(.DIV(CLK_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (os_tick)
    );

    mpuart_tx #(.BIT_CLKS(BIT_CLKS), .PARITY_EN(PARITY_EN)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (ctrl_txe),
        .len8    (len8_eff),
        .mode    (mode),
        .adr_flag(ctrl_adr),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .txd     (txd)
    );

    mpuart_rx #(.OVS(OVS), .PARITY_EN(PARITY_EN)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (ctrl_rxe),
        .os_tick(os_tick),
        .rxd_s  (rxd_sync[1]),
        .len8   (len8_eff),
        .mode   (mode),
        .done   (rx_done),
        .frm_err(rx_ferr),
        .par_err(rx_perr),
        .xbit   (rx_xbit),
        .data   (rx_word)
    );

    mpuart_brk #(.LIMIT(BRK_TICKS)) u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mode == 2'd3),
        .os_tick(os_tick),
        .rxd_s  (rxd_sync[1]),
        .hit    (brk_hit)
    );

endmodule

// File: rtl/mpuart_sva.sv
// Module: protocol checker for the serial transceiver, bound to mpuart.
// Assumes synchronous active-low reset on rst_n.
module mpuart_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       rx_en,
    input logic       txd,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       err_clr_req,
    input logic       brk_clr_req,
    input logic [3:0] status,
    input logic [1:0] mode
);

    // R11: a disabled transmitter drives the idle level
    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);

    // R13: an accepted byte starts its frame on the next cycle
    assert_start_after_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd);

    // R10: a byte appears only while reception was enabled
    assert_rx_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(rx_en));

    // R8: an unread byte stays put
    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R9: the clear strobe empties the receive error flags
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_req |=> (status[2:0] == 3'b000));

    // R12: break flag is sticky until cleared
    assert_brk_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !brk_clr_req) |=> status[3]);

    // R12: break flag rises only in mode 3
    assert_brk_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> ($past(mode) == 2'd3));

endmodule

bind mpuart mpuart_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (ctrl_txe),
    .rx_en      (ctrl_rxe),
    .txd        (txd),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .err_clr_req(reg_wr && !reg_addr && reg_wdata[4]),
    .brk_clr_req(reg_wr && reg_addr && reg_wdata[3]),
    .status     (status),
    .mode       (mode)
);

// File: tb/mpuart_test.sv
`timescale 1ns/1ps
module mpuart_test;

    localparam int BIT = 32;   // CLK_DIV * OVS with defaults

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [3:0] status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mpuart uut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .status(status)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected frame image from the requirements; returns the bit count
    function automatic int exp_frame(input logic [7:0] d, input bit len8, input logic [1:0] md,
                                     input bit ad, output logic [11:0] bits);
        int nd;
        int p;
        logic [7:0] dm;
        nd   = (len8 || md >= 2) ? 8 : 7;
        dm   = (nd == 8) ? d : {1'b0, d[6:0]};
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nd; i++) bits[1+i] = dm[i];
        p = 1 + nd;
        if (md == 2'd1) begin
            bits[p] = ad;
            p++;
        end else if (md == 2'd0) begin
            bits[p] = ^dm;
            p++;
        end
        bits[p] = 1'b1;
        return p + 1;
    endfunction

    task automatic reg_write(input logic a, input logic [4:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic a, output logic [4:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // control layout: [0] rx en, [1] tx en, [2] len8, [3] marker, [4] clear
    task automatic set_ctrl(input bit rxe, input bit txe, input bit len8, input bit ad);
        reg_write(1'b0, {1'b0, ad, len8, txe, rxe});
    endtask

    task automatic tx_start(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic tx_check(input logic [7:0] d, input bit len8, input logic [1:0] md,
                            input bit ad, input string req);
        logic [11:0] e;
        logic [11:0] got;
        int n;
        n = exp_frame(d, len8, md, ad, e);
        got = '1;
        tx_start(d);
        repeat (BIT/2 - 1) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) repeat (BIT) @(negedge clk);
        end
        chk(got == e, req, got, e);
        repeat (BIT) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] d, input bit len8, input logic [1:0] md,
                           input bit ad, input bit bad_par, input bit bad_stop);
        logic [11:0] b;
        int n;
        int nd;
        n  = exp_frame(d, len8, md, ad, b);
        nd = (len8 || md >= 2) ? 8 : 7;
        if (bad_par) b[1+nd] = ~b[1+nd];
        if (bad_stop) b[n-1] = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rxd = b[i];
            repeat (BIT - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_take(output logic [7:0] d, output bit v);
        @(negedge clk);
        v = rx_valid; d = rx_data;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic drive_low(input int bits);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bits * BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R13 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0] rd;
        logic [7:0] d;
        logic [7:0] d2;
        bit v;
        int unsigned seed;
        seed = 32'd4242;
        void'($urandom(seed));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(status == 4'h0, "R1 status", status, 0);
        reg_read(1'b0, rd);
        chk(rd == 5'h0, "R1 ctrl read", rd, 0);
        reg_read(1'b1, rd);
        chk(rd == 5'h0, "R1 status read", rd, 0);

        // R2 lengths, R6 parity in mode 0
        mode = 2'd0;
        set_ctrl(1, 1, 1, 0);
        tx_check(8'hA5, 1, 2'd0, 0, "R2 8-bit frame");
        set_ctrl(1, 1, 0, 0);
        tx_check(8'hFF, 0, 2'd0, 0, "R2 7-bit frame");
        tx_check(8'h03, 0, 2'd0, 0, "R6 parity bit");

        // R3 forced 8 bits
        mode = 2'd2;
        tx_check(8'hC3, 1, 2'd2, 0, "R3 mode 2 forces 8 bits");
        mode = 2'd3;
        tx_check(8'h81, 1, 2'd3, 0, "R3 mode 3 forces 8 bits");

        // R4 marker bit
        mode = 2'd1;
        set_ctrl(1, 1, 1, 1);
        tx_check(8'h5A, 1, 2'd1, 1, "R4 address frame");
        set_ctrl(1, 1, 0, 0);
        tx_check(8'h2C, 0, 2'd1, 0, "R4 data frame");

        // R5 received marker readback
        set_ctrl(1, 1, 1, 0);
        rx_send(8'h9E, 1, 2'd1, 1, 0, 0);
        reg_read(1'b0, rd);
        chk(rd[3] == 1'b1, "R5 marker read 1", rd[3], 1);
        rx_take(d, v);
        chk(v && d == 8'h9E, "R5 data", d, 8'h9E);
        rx_send(8'h11, 1, 2'd1, 0, 0, 0);
        reg_read(1'b0, rd);
        chk(rd[3] == 1'b0, "R5 marker read 0", rd[3], 0);
        rx_take(d, v);
        chk(status == 4'h0, "R4 no parity check in mode 1", status, 0);

        // R6 parity error; R9 clear semantics
        mode = 2'd0;
        rx_send(8'h37, 1, 2'd0, 0, 1, 0);
        rx_take(d, v);
        chk(status[2] == 1'b1, "R6 parity error", status, 4'h4);
        set_ctrl(1, 1, 1, 0);
        chk(status[2] == 1'b1, "R9 write without clear", status, 4'h4);
        reg_write(1'b0, 5'b10111);
        chk(status[2:0] == 3'b000, "R9 clear", status, 0);
        reg_read(1'b0, rd);
        chk(rd[4] == 1'b0, "R9 clear reads 0", rd, 5'h07);

        // R2 7-bit receive
        set_ctrl(1, 1, 0, 0);
        rx_send(8'hF5, 0, 2'd0, 0, 0, 0);
        rx_take(d, v);
        chk(v && d == 8'h75, "R2 7-bit receive", d, 8'h75);
        chk(status == 4'h0, "R6 good parity", status, 0);

        // R7 framing
        set_ctrl(1, 1, 1, 0);
        rx_send(8'h42, 1, 2'd0, 0, 0, 1);
        rx_take(d, v);
        chk(status[0] == 1'b1, "R7 framing error", status, 4'h1);
        reg_write(1'b0, 5'b10111);

        // R8 overrun
        rx_send(8'h12, 1, 2'd0, 0, 0, 0);
        rx_send(8'h34, 1, 2'd0, 0, 0, 0);
        chk(status[1] == 1'b1, "R8 overrun flag", status, 4'h2);
        rx_take(d, v);
        chk(v && d == 8'h12, "R8 old byte kept", d, 8'h12);
        reg_write(1'b0, 5'b10111);

        // R10 receive abort
        fork
            rx_send(8'h66, 1, 2'd0, 0, 0, 0);
            begin
                repeat (4 * BIT) @(negedge clk);
                set_ctrl(0, 1, 1, 0);
            end
        join
        set_ctrl(1, 1, 1, 0);
        repeat (BIT) @(negedge clk);
        chk(rx_valid == 1'b0, "R10 aborted frame not reported", rx_valid, 0);
        rx_send(8'h77, 1, 2'd0, 0, 0, 0);
        rx_take(d, v);
        chk(v && d == 8'h77, "R10 receive after abort", d, 8'h77);

        // R11 transmit abort
        tx_start(8'h00);
        repeat (3 * BIT) @(negedge clk);
        set_ctrl(1, 0, 1, 0);
        @(negedge clk);
        v = 1'b1;
        for (int i = 0; i < 3 * BIT; i++) begin
            if (!txd || tx_ready) v = 1'b0;
            @(negedge clk);
        end
        chk(v, "R11 line idle and not ready while disabled", v, 1);
        set_ctrl(1, 1, 1, 0);
        chk(tx_ready == 1'b1, "R11 ready after re-enable", tx_ready, 1);

        // R12 break detection with receiver off
        mode = 2'd3;
        set_ctrl(0, 1, 1, 0);
        drive_low(10);
        chk(status[3] == 1'b0, "R12 10 bit times", status, 0);
        drive_low(12);
        chk(status[3] == 1'b1, "R12 12 bit times", status, 4'h8);
        repeat (2 * BIT) @(negedge clk);
        chk(status[3] == 1'b1, "R12 sticky", status, 4'h8);
        reg_write(1'b1, 5'b01000);
        chk(status[3] == 1'b0, "R12 cleared", status, 0);
        mode = 2'd0;
        drive_low(12);
        chk(status[3] == 1'b0, "R12 not in mode 0", status, 0);

        // random frames, all modes
        for (int k = 0; k < 16; k++) begin
            logic [1:0] md;
            bit ln;
            bit ad;
            bit l8;
            md = 2'($urandom_range(0, 3));
            ln = 1'($urandom_range(0, 1));
            ad = 1'($urandom_range(0, 1));
            d2 = 8'($urandom_range(0, 255));
            l8 = ln || md >= 2;
            mode = md;
            set_ctrl(1, 1, ln, ad);
            tx_check(d2, ln, md, ad, "R13 random transmit");
            rx_send(d2, ln, md, ad, 0, 0);
            if (md == 2'd1) begin
                reg_read(1'b0, rd);
                chk(rd[3] == ad, "R5 random marker", rd[3], ad);
            end
            rx_take(d, v);
            chk(v && d == (l8 ? d2 : {1'b0, d2[6:0]}), "R2 random receive", d, d2);
            chk(status == 4'h0, "R7 no false error", status, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule